// File: doc/BRIEF.md
# Four-Lane Signed Sum-of-Products Slice

This block multiplies four signed 18-bit data operands by four signed 18-bit coefficients and delivers the sum of the four products as one 38-bit result. Each lane keeps its data operand and its coefficient in its own register. A two-bit mode selects, separately for data and for coefficients, whether a lane register takes its own slice of a wide parallel bus or takes the value of the lane before it. In the second case the four registers form a tap delay line fed from a narrow stream input. The last register of each line is also driven out, so a following slice can continue the line. Because the two choices are independent, a filter can keep shifting samples down its data line while a full coefficient set is swapped in one transfer.

The products pass through an optional pipeline register, selected by a parameter, and then through a two-level adder tree into the output register. Input and output use valid/ready. The whole pipeline advances together whenever the output register is empty or is being read. `in_ready` tells the source when a transfer can be taken. While `out_valid` is high and `out_ready` is low, nothing moves: the output holds and no new transfer is taken. A cycle without `in_valid` changes no operand register and inserts a bubble that produces no output.

Top module: `sop4_slice`

## Requirements
- R1: A synchronous reset clears every operand, pipeline and output register, so `out_valid`, `out_sum`, `data_casc` and `coef_casc` read zero after it.
- R2: `out_sum` equals the exact signed sum of the four lane products (data lane i times coefficient lane i, two's complement). Four products of -131072 by -131072 give 2^36 with no overflow.
- R3: The mode encoding is: bit 0 set chains the data registers, bit 1 set chains the coefficient registers. 00 loads both in parallel, 11 chains both. A register that loads in parallel takes bits [18*i+17 : 18*i] of its parallel bus for lane i.
- R4: On a taken transfer, a chained line moves by exactly one register. Lane 0 takes the stream input and lane i takes the old value of lane i-1.
- R5: With mode 01, data moves along its line while all four coefficients are replaced from the parallel bus in the same transfer. Mode 10 is the mirror image.
- R6: `data_casc` and `coef_casc` always show the lane 3 data and coefficient registers.
- R7: The result of a transfer taken at clock edge E appears with `out_valid` high after edge E+2 when PIPE_EN=1, and after edge E+1 when PIPE_EN=0, if the pipeline is not stalled.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_sum`, `out_valid` and the operand registers hold.
- R9: A cycle with `in_valid` low changes no operand register and yields no output beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | bit0 chains data, bit1 chains coefficients |
| in_valid | input | 1 | An operand transfer is offered |
| in_ready | output | 1 | The slice takes the offered transfer |
| data_in | input | 18 | Stream input to the data line (lane 0) |
| coef_in | input | 18 | Stream input to the coefficient line (lane 0) |
| data_par | input | 72 | Parallel data, lane i in bits [18i+17:18i] |
| coef_par | input | 72 | Parallel coefficients, lane i in bits [18i+17:18i] |
| out_valid | output | 1 | `out_sum` holds a result |
| out_ready | input | 1 | The consumer takes the result |
| out_sum | output | 38 | Signed sum of the four products |
| data_casc | output | 18 | Lane 3 data register, for the next slice |
| coef_casc | output | 18 | Lane 3 coefficient register, for the next slice |

## Verification
A stall and an offered transfer can fall in the same cycle. With `out_ready` low on a full output, a transfer that carries a mode change and fresh parallel operands must be refused. It must also leave both delay lines and the held result untouched. The bench provokes this by driving random `in_valid`, `out_ready` and mode together for a long stretch. It judges every cycle against a behavioural model whose stage queue moves only when its own output slot is empty or read. The same stimulus drives a second slice built without the pipeline register, which compares the two latencies.

// File: rtl/sop4_pkg.sv
package sop4_pkg;
  // bit0: data lane registers chained, bit1: coefficient lane registers chained
  typedef enum logic [1:0] {
    LD_BOTH_PAR   = 2'b00,
    LD_DATA_CHAIN = 2'b01,
    LD_COEF_CHAIN = 2'b10,
    LD_BOTH_CHAIN = 2'b11
  } ld_mode_e;
endpackage

// File: rtl/sop4_operand_line.sv
module sop4_operand_line #(
  parameter int LANES = 4,
  parameter int W     = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               chain,
  input  logic [W-1:0]       ser_in,
  input  logic [LANES*W-1:0] par_in,
  output logic [LANES*W-1:0] q,
  output logic [W-1:0]       casc_out
);
  logic [W-1:0] lane_q [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [W-1:0] prev_v;
    if (i == 0) begin : g_head
      assign prev_v = ser_in;
    end else begin : g_body
      assign prev_v = lane_q[i-1];
    end

    always_ff @(posedge clk) begin
      if (rst) lane_q[i] <= '0;
      else if (load) lane_q[i] <= chain ? prev_v : par_in[i*W +: W];
    end

    assign q[i*W +: W] = lane_q[i];

    if (i > 0) begin : g_chk
      AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (rst)
        (load && chain) |=> (lane_q[i] == $past(lane_q[i-1]))); // R4
    end
  end

  assign casc_out = lane_q[LANES-1];

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q)); // R9
endmodule

// File: rtl/sop4_mult_stage.sv
module sop4_mult_stage #(
  parameter int LANES = 4,
  parameter int AW    = 18,
  parameter int BW    = 18,
  localparam int PW   = AW + BW
) (
  input  logic [LANES*AW-1:0] a_vec,
  input  logic [LANES*BW-1:0] b_vec,
  output logic [LANES*PW-1:0] prod_vec
);
  for (genvar i = 0; i < LANES; i++) begin : g_mul
    logic signed [AW-1:0] a_s;
    logic signed [BW-1:0] b_s;
    logic signed [PW-1:0] p_s;
    assign a_s = a_vec[i*AW +: AW];
    assign b_s = b_vec[i*BW +: BW];
    assign p_s = PW'(a_s) * PW'(b_s);
    assign prod_vec[i*PW +: PW] = p_s;
  end
endmodule

// File: rtl/sop4_adder_tree.sv
module sop4_adder_tree #(
  parameter int LANES = 4,
  parameter int PW    = 36,
  localparam int NP   = LANES / 2,
  localparam int SW   = PW + $clog2(LANES)
) (
  input  logic [LANES*PW-1:0] prod_vec,
  output logic [SW-1:0]       sum
);
  logic signed [PW:0] pair_s [NP];

  // first level: neighbouring products
  for (genvar p = 0; p < NP; p++) begin : g_pair
    logic signed [PW-1:0] lo_s, hi_s;
    assign lo_s = prod_vec[(2*p)*PW +: PW];
    assign hi_s = prod_vec[(2*p+1)*PW +: PW];
    assign pair_s[p] = (PW+1)'(lo_s) + (PW+1)'(hi_s);
  end

  // second level: pair sums
  always_comb begin
    logic signed [SW-1:0] acc;
    acc = '0;
    for (int p = 0; p < NP; p++) acc = acc + SW'(pair_s[p]);
    sum = acc;
  end
endmodule

// File: rtl/sop4_slice.sv
module sop4_slice
  import sop4_pkg::*;
#(
  parameter int AW      = 18,
  parameter int BW      = 18,
  parameter int LANES   = 4,
  parameter bit PIPE_EN = 1'b1,
  localparam int PW     = AW + BW,
  localparam int SW     = PW + $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mode,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [AW-1:0]      data_in,
  input  logic [BW-1:0]      coef_in,
  input  logic [LANES*AW-1:0] data_par,
  input  logic [LANES*BW-1:0] coef_par,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [SW-1:0]      out_sum,
  output logic [AW-1:0]      data_casc,
  output logic [BW-1:0]      coef_casc
);
  ld_mode_e mode_e;
  logic adv, take, data_chain, coef_chain;
  logic v_in, src_v;
  logic [LANES*AW-1:0] a_vec;
  logic [LANES*BW-1:0] b_vec;
  logic [LANES*PW-1:0] prod_c, tree_in;
  logic [SW-1:0] tree_sum;

  assign mode_e     = ld_mode_e'(mode);
  assign data_chain = (mode_e == LD_DATA_CHAIN) || (mode_e == LD_BOTH_CHAIN);
  assign coef_chain = (mode_e == LD_COEF_CHAIN) || (mode_e == LD_BOTH_CHAIN);
  assign adv        = !out_valid || out_ready;
  assign in_ready   = adv;
  assign take       = in_valid && adv;

  sop4_operand_line #(.LANES(LANES), .W(AW)) u_data_line (
    .clk(clk), .rst(rst), .load(take), .chain(data_chain),
    .ser_in(data_in), .par_in(data_par), .q(a_vec), .casc_out(data_casc)
  );

  sop4_operand_line #(.LANES(LANES), .W(BW)) u_coef_line (
    .clk(clk), .rst(rst), .load(take), .chain(coef_chain),
    .ser_in(coef_in), .par_in(coef_par), .q(b_vec), .casc_out(coef_casc)
  );

  always_ff @(posedge clk) begin
    if (rst) v_in <= 1'b0;
    else if (adv) v_in <= in_valid;
  end

  sop4_mult_stage #(.LANES(LANES), .AW(AW), .BW(BW)) u_mult (
    .a_vec(a_vec), .b_vec(b_vec), .prod_vec(prod_c)
  );

  if (PIPE_EN) begin : g_pipe
    logic [LANES*PW-1:0] prod_r;
    logic v_pp;
    always_ff @(posedge clk) begin
      if (rst) begin
        prod_r <= '0;
        v_pp   <= 1'b0;
      end else if (adv) begin
        prod_r <= prod_c;
        v_pp   <= v_in;
      end
    end
    assign tree_in = prod_r;
    assign src_v   = v_pp;

    AST_PIPE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(prod_r)); // R8
  end else begin : g_direct
    assign tree_in = prod_c;
    assign src_v   = v_in;
  end

  sop4_adder_tree #(.LANES(LANES), .PW(PW)) u_tree (
    .prod_vec(tree_in), .sum(tree_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else if (adv) begin
      out_valid <= src_v;
      if (src_v) out_sum <= tree_sum;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum))); // R8

  AST_STALL_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> ($stable(data_casc) && $stable(coef_casc))); // R8
endmodule

// File: tb/sop4_slice_tb_top.sv
module sop4_slice_tb_top;
  localparam int AW = 18;
  localparam int L  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk; // 125 MHz

  logic [1:0]      mode = '0;
  logic            in_valid = 1'b0;
  logic [AW-1:0]   data_in = '0, coef_in = '0;
  logic [L*AW-1:0] data_par = '0, coef_par = '0;
  logic            ordy_a = 1'b1;
  logic            rdy_a, rdy_b, ov_a, ov_b;
  logic [37:0]     sum_a, sum_b;
  logic [AW-1:0]   dc_a, cc_a, dc_b, cc_b;

  sop4_slice #(.PIPE_EN(1'b1)) dut_i (
    .clk(clk), .rst(rst), .mode(mode), .in_valid(in_valid), .in_ready(rdy_a),
    .data_in(data_in), .coef_in(coef_in), .data_par(data_par), .coef_par(coef_par),
    .out_valid(ov_a), .out_ready(ordy_a), .out_sum(sum_a),
    .data_casc(dc_a), .coef_casc(cc_a)
  );

  sop4_slice #(.PIPE_EN(1'b0)) dut_nopipe_i (
    .clk(clk), .rst(rst), .mode(mode), .in_valid(in_valid), .in_ready(rdy_b),
    .data_in(data_in), .coef_in(coef_in), .data_par(data_par), .coef_par(coef_par),
    .out_valid(ov_b), .out_ready(1'b1), .out_sum(sum_b),
    .data_casc(dc_b), .coef_casc(cc_b)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;

  // behavioural model: lane contents and a queue of stage slots per slice
  int     md [2][L];
  int     mc [2][L];
  bit     qv [2][3];
  longint qs [2][3];
  int     lat [2] = '{3, 2};

  task automatic chk(bit ok, string req, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sx18(logic [AW-1:0] v);
    logic signed [AW-1:0] s;
    s = v;
    return int'(s);
  endfunction

  task automatic check_out(int d, string tag);
    logic ov;
    logic [37:0] s;
    logic [AW-1:0] dc, cc;
    int k;
    ov = d ? ov_b : ov_a;
    s  = d ? sum_b : sum_a;
    dc = d ? dc_b : dc_a;
    cc = d ? cc_b : cc_a;
    k  = lat[d] - 1;
    chk(ov == qv[d][k], "R7", longint'(ov), longint'(qv[d][k]));
    if (qv[d][k]) begin
      logic signed [37:0] ss;
      ss = s;
      chk(longint'(ss) == qs[d][k], tag, longint'(ss), qs[d][k]);
    end
    chk(sx18(dc) == md[d][L-1], "R6", sx18(dc), md[d][L-1]);
    chk(sx18(cc) == mc[d][L-1], "R6", sx18(cc), mc[d][L-1]);
  endtask

  task automatic model_step(int d, bit ordy);
    int k;
    bit adv;
    bit rdy;
    k   = lat[d] - 1;
    adv = !qv[d][k] || ordy;
    rdy = d ? rdy_b : rdy_a;
    chk(rdy == adv, "R8", longint'(rdy), longint'(adv));
    if (adv) begin
      for (int j = k; j > 0; j--) begin
        qv[d][j] = qv[d][j-1];
        qs[d][j] = qs[d][j-1];
      end
      if (in_valid) begin
        longint acc = 0;
        for (int i = L-1; i >= 0; i--) begin
          if (mode[0]) md[d][i] = (i == 0) ? sx18(data_in) : md[d][i-1];
          else         md[d][i] = sx18(data_par[i*AW +: AW]);
          if (mode[1]) mc[d][i] = (i == 0) ? sx18(coef_in) : mc[d][i-1];
          else         mc[d][i] = sx18(coef_par[i*AW +: AW]);
        end
        for (int i = 0; i < L; i++) acc += longint'(md[d][i]) * longint'(mc[d][i]);
        qv[d][0] = 1'b1;
        qs[d][0] = acc;
      end else begin
        qv[d][0] = 1'b0;
      end
    end
  endtask

  // one clock: check outputs, drive the next inputs, advance the model
  task automatic cyc(string tag, logic [1:0] m, logic v, logic ordy, bit extreme);
    @(negedge clk);
    check_out(0, tag);
    check_out(1, tag);
    mode     = m;
    in_valid = v;
    ordy_a   = ordy;
    data_in  = AW'($urandom);
    coef_in  = AW'($urandom);
    for (int i = 0; i < L; i++) begin
      data_par[i*AW +: AW] = extreme ? 18'h20000 : AW'($urandom);
      coef_par[i*AW +: AW] = extreme ? 18'h20000 : AW'($urandom);
    end
    #1;
    model_step(0, ordy);
    model_step(1, 1'b1);
  endtask

  initial begin
    for (int d = 0; d < 2; d++) begin
      for (int i = 0; i < L; i++) begin md[d][i] = 0; mc[d][i] = 0; end
      for (int j = 0; j < 3; j++) begin qv[d][j] = 0; qs[d][j] = 0; end
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(!ov_a && !ov_b, "R1", longint'(ov_a), 0);
    chk(sum_a == '0 && sum_b == '0, "R1", longint'(sum_a), 0);
    chk(dc_a == '0 && cc_a == '0 && dc_b == '0 && cc_b == '0, "R1", longint'(dc_a), 0);

    for (int n = 0; n < 20; n++) cyc("R3", 2'b00, 1'b1, 1'b1, 1'b0);
    for (int n = 0; n < 3;  n++) cyc("R2", 2'b00, 1'b1, 1'b1, 1'b1);
    for (int n = 0; n < 20; n++) cyc("R4", 2'b11, 1'b1, 1'b1, 1'b0);
    for (int n = 0; n < 20; n++) cyc("R5", 2'b01, 1'b1, 1'b1, 1'b0);
    for (int n = 0; n < 15; n++) cyc("R5", 2'b10, 1'b1, 1'b1, 1'b0);
    for (int n = 0; n < 400; n++)
      cyc("R8", 2'($urandom), 1'($urandom), 1'($urandom), 1'b0);
    for (int n = 0; n < 15; n++) cyc("R9", 2'($urandom), 1'b0, 1'($urandom), 1'b0);
    for (int n = 0; n < 30; n++) cyc("R9", 2'b11, 1'(n % 2), 1'($urandom), 1'b0);
    for (int n = 0; n < 8;  n++) cyc("R2", 2'b00, 1'b0, 1'b1, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule